// File: doc/BRIEF.md
# E-Paper Panel Bring-Up and Full-Refresh Sequencer

This block runs the power-on and full-refresh command scripts for a display made of two cascaded e-paper controllers. It drives the panel's active-low reset line, watches the panel's active-high busy line, and sends command and data bytes to a serial framer next to it. The framer turns each byte into a serial transfer. It sets the data/command select from the byte's kind and brackets each group of bytes with chip select. All timing comes from a 1 kHz tick input, so every delay and busy limit is a count of ticks. A simulation can therefore speed up the tick and shrink the limits.

Two operations are available. The first is a panel reset followed by the init script, which loads the temperature value and the waveform tables. The second is a full refresh. A refresh starts by asking a neighbouring window block, through a req/ack handshake, to program the RAM window on both controllers. It then sends the cascade update-control setting, the temperature value and the fast-update mode, and it triggers the update. A busy wait that runs past its limit gives up, sets a sticky timeout flag and lets the script go on. The flag is cleared when the next operation is accepted.

Bytes leave on a valid/ready stream. Once valid is high, the byte and its two attribute bits stay frozen until ready is seen, and valid does not drop. The framer may hold ready low for any length of time, and the script simply pauses.

Top module: `epd_seq_top`

## Requirements
- R1: After reset, panel_rst_n is 1, idle is 1, and out_valid, win_req and timeout_flag are all 0.
- R2: The init byte stream is exactly: 0x12; 0x18, 0x80; 0x22, 0xB1; 0x20; 0x1A, 0x64, 0x00; 0x22, 0x91; 0x20. A command byte has out_is_data=0 and out_last=1. A data byte has out_is_data=1, and out_last=1 only on the final byte of its group.
- R3: While out_valid is 1 and out_ready is 0, out_valid stays 1, and out_byte, out_is_data and out_last stay unchanged.
- R4: Init begins with panel_rst_n high for RST_MS ticks, then low for RST_MS ticks, then high again. No byte is offered while panel_rst_n is low.
- R5: After command 0x12 and after each 0x20 in init, the sequencer waits CMD_MS ticks. It then waits for busy_i to go low before it offers the next byte.
- R6: A busy wait that sees busy_i high for its full limit sets timeout_flag, and the script continues to its end. The flag then stays set while the block is idle.
- R7: timeout_flag is cleared in the cycle after an operation is accepted.
- R8: A refresh first raises win_req and holds it until win_ack. No byte is offered before then. The refresh stream is then 0x21, 0x40, 0x10; 0x1A, 0x64, 0x00; 0x22, 0xD7; 0x20.
- R9: Start requests are ignored while idle is 0.
- R10: The busy wait after the refresh trigger uses the BUSY_LONG_MS limit. The busy waits in init use the BUSY_SHORT_MS limit.
- R11: When start_init and start_refresh arrive in the same idle cycle, init runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| start_init | input | 1 | Request panel reset plus init |
| start_refresh | input | 1 | Request full refresh |
| busy_i | input | 1 | Panel busy, active high, asynchronous |
| panel_rst_n | output | 1 | Panel reset line, active low |
| out_valid | output | 1 | Byte offered to framer |
| out_ready | input | 1 | Framer accepts byte |
| out_byte | output | 8 | Command or data byte |
| out_is_data | output | 1 | 1 = data byte, 0 = command byte |
| out_last | output | 1 | Last byte of a chip-select group |
| win_req | output | 1 | Ask neighbour to program refresh window |
| win_ack | input | 1 | Neighbour finished window setup |
| idle | output | 1 | No operation running |
| timeout_flag | output | 1 | Sticky: a busy wait gave up |

## Verification
Init is run with busy pulses shorter than the limit and with the ready line toggled by a pseudo-random pattern. This separates correct waiting and back-pressure handling from skipped waits and from bytes that change while they are stalled. Busy held high during init and again during refresh shows the timeout path, separates the short limit from the long one, and shows that the flag stays set and is later cleared. A refresh with a delayed window acknowledge, a start pulse sent in the middle of an operation, and start pulses arriving together show the handshake ordering, that requests are ignored while running, and the init priority.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  localparam int PC_W     = 6;
  localparam int REF_BASE = 32;

  typedef enum logic [2:0] {
    OP_END = 3'd0,
    OP_PIN = 3'd1,
    OP_CMD = 3'd2,
    OP_DAT = 3'd3,
    OP_DLY = 3'd4,
    OP_BSY = 3'd5,
    OP_WIN = 3'd6
  } op_e;

  // sel: DLY 0=reset delay 1=post-command delay; BSY 0=short 1=long limit
  typedef struct packed {
    op_e        op;
    logic       sel;
    logic       last;
    logic [7:0] val;
  } step_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DLY  = 2'd2,
    ST_BSY  = 2'd3
  } state_e;

endpackage

// File: rtl/epd_script_rom.sv
module epd_script_rom
  import epd_seq_pkg::*;
(
  input  logic [PC_W-1:0] idx,
  output step_t           step
);

  function automatic step_t mk(op_e o, logic s, logic l, logic [7:0] v);
    step_t t;
    t.op = o; t.sel = s; t.last = l; t.val = v;
    return t;
  endfunction

  always_comb begin
    case (idx)
      // reset and init
      6'd0:  step = mk(OP_PIN, 1'b0, 1'b0, 8'h01);
      6'd1:  step = mk(OP_DLY, 1'b0, 1'b0, 8'h00);
      6'd2:  step = mk(OP_PIN, 1'b0, 1'b0, 8'h00);
      6'd3:  step = mk(OP_DLY, 1'b0, 1'b0, 8'h00);
      6'd4:  step = mk(OP_PIN, 1'b0, 1'b0, 8'h01);
      6'd5:  step = mk(OP_DLY, 1'b0, 1'b0, 8'h00);
      6'd6:  step = mk(OP_BSY, 1'b0, 1'b0, 8'h00);
      6'd7:  step = mk(OP_CMD, 1'b0, 1'b1, 8'h12);
      6'd8:  step = mk(OP_DLY, 1'b1, 1'b0, 8'h00);
      6'd9:  step = mk(OP_BSY, 1'b0, 1'b0, 8'h00);
      6'd10: step = mk(OP_CMD, 1'b0, 1'b1, 8'h18);
      6'd11: step = mk(OP_DAT, 1'b0, 1'b1, 8'h80);
      6'd12: step = mk(OP_CMD, 1'b0, 1'b1, 8'h22);
      6'd13: step = mk(OP_DAT, 1'b0, 1'b1, 8'hB1);
      6'd14: step = mk(OP_CMD, 1'b0, 1'b1, 8'h20);
      6'd15: step = mk(OP_DLY, 1'b1, 1'b0, 8'h00);
      6'd16: step = mk(OP_BSY, 1'b0, 1'b0, 8'h00);
      6'd17: step = mk(OP_CMD, 1'b0, 1'b1, 8'h1A);
      6'd18: step = mk(OP_DAT, 1'b0, 1'b0, 8'h64);
      6'd19: step = mk(OP_DAT, 1'b0, 1'b1, 8'h00);
      6'd20: step = mk(OP_CMD, 1'b0, 1'b1, 8'h22);
      6'd21: step = mk(OP_DAT, 1'b0, 1'b1, 8'h91);
      6'd22: step = mk(OP_CMD, 1'b0, 1'b1, 8'h20);
      6'd23: step = mk(OP_DLY, 1'b1, 1'b0, 8'h00);
      6'd24: step = mk(OP_BSY, 1'b0, 1'b0, 8'h00);
      // full refresh
      6'd32: step = mk(OP_WIN, 1'b0, 1'b0, 8'h00);
      6'd33: step = mk(OP_CMD, 1'b0, 1'b1, 8'h21);
      6'd34: step = mk(OP_DAT, 1'b0, 1'b0, 8'h40);
      6'd35: step = mk(OP_DAT, 1'b0, 1'b1, 8'h10);
      6'd36: step = mk(OP_CMD, 1'b0, 1'b1, 8'h1A);
      6'd37: step = mk(OP_DAT, 1'b0, 1'b0, 8'h64);
      6'd38: step = mk(OP_DAT, 1'b0, 1'b1, 8'h00);
      6'd39: step = mk(OP_CMD, 1'b0, 1'b1, 8'h22);
      6'd40: step = mk(OP_DAT, 1'b0, 1'b1, 8'hD7);
      6'd41: step = mk(OP_CMD, 1'b0, 1'b1, 8'h20);
      6'd42: step = mk(OP_BSY, 1'b1, 1'b0, 8'h00);
      default: step = mk(OP_END, 1'b0, 1'b0, 8'h00);
    endcase
  end

endmodule

// File: rtl/epd_tick_timer.sv
module epd_tick_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !tick |=> $stable(cnt)); // R4

endmodule

// File: rtl/epd_busy_sync.sv
module epd_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_flops
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/epd_seq_top.sv
module epd_seq_top
  import epd_seq_pkg::*;
#(
  parameter int RST_MS        = 20,
  parameter int CMD_MS        = 10,
  parameter int BUSY_SHORT_MS = 100,
  parameter int BUSY_LONG_MS  = 2500,
  parameter int SYNC_STAGES   = 2,
  parameter int TMR_W         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_init,
  input  logic       start_refresh,
  input  logic       busy_i,
  output logic       panel_rst_n,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       out_is_data,
  output logic       out_last,
  output logic       win_req,
  input  logic       win_ack,
  output logic       idle,
  output logic       timeout_flag
);

  state_e          state;
  logic [PC_W-1:0] pc;
  step_t           cur;
  logic            busy_s;
  logic            tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic            tmr_done;
  logic            rst_q;
  logic            tof_q;
  logic            op_accept;

  epd_script_rom u_rom (.idx(pc), .step(cur));

  epd_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_i), .q(busy_s));

  epd_tick_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(tick), .expired(tmr_done));

  always_comb begin
    out_valid   = (state == ST_RUN) && (cur.op == OP_CMD || cur.op == OP_DAT);
    out_byte    = cur.val;
    out_is_data = (cur.op == OP_DAT);
    out_last    = cur.last;
    win_req     = (state == ST_RUN) && (cur.op == OP_WIN);
    tmr_load    = (state == ST_RUN) && (cur.op == OP_DLY || cur.op == OP_BSY);
    if (cur.op == OP_DLY)
      tmr_val = cur.sel ? TMR_W'(CMD_MS) : TMR_W'(RST_MS);
    else
      tmr_val = cur.sel ? TMR_W'(BUSY_LONG_MS) : TMR_W'(BUSY_SHORT_MS);
    op_accept   = (state == ST_IDLE) && (start_init || start_refresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      rst_q <= 1'b1;
      tof_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_init) begin
            pc    <= '0;
            state <= ST_RUN;
            tof_q <= 1'b0;
          end else if (start_refresh) begin
            pc    <= PC_W'(REF_BASE);
            state <= ST_RUN;
            tof_q <= 1'b0;
          end
        end
        ST_RUN: begin
          case (cur.op)
            OP_END: state <= ST_IDLE;
            OP_PIN: begin
              rst_q <= cur.val[0];
              pc    <= pc + PC_W'(1);
            end
            OP_CMD, OP_DAT: if (out_ready) pc <= pc + PC_W'(1);
            OP_DLY: state <= ST_DLY;
            OP_BSY: state <= ST_BSY;
            OP_WIN: if (win_ack) pc <= pc + PC_W'(1);
            default: state <= ST_IDLE;
          endcase
        end
        ST_DLY: begin
          if (tmr_done) begin
            pc    <= pc + PC_W'(1);
            state <= ST_RUN;
          end
        end
        ST_BSY: begin
          if (!busy_s) begin
            pc    <= pc + PC_W'(1);
            state <= ST_RUN;
          end else if (tmr_done) begin
            tof_q <= 1'b1;
            pc    <= pc + PC_W'(1);
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign panel_rst_n  = rst_q;
  assign timeout_flag = tof_q;
  assign idle         = (state == ST_IDLE);

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte)
      && $stable(out_is_data) && $stable(out_last)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !out_valid && !win_req); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag && !op_accept |=> timeout_flag); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> !timeout_flag); // R7
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    win_req && !win_ack |=> win_req); // R8
  AST_RST_NOBYTES: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !out_valid); // R4

endmodule

// File: tb/sim_epd_seq_top.sv
module sim_epd_seq_top;
  localparam int RST_T = 3, CMD_T = 2, BS_T = 8, BL_T = 12;
  localparam int TICK_DIV = 5, BUSY_CYC = 30, WIN_WAIT = 7;

  logic clk = 0, rst_n = 0, tick = 0, start_init = 0, start_refresh = 0;
  logic busy = 0, out_ready = 1, win_ack = 0;
  logic panel_rst_n, out_valid, out_is_data, out_last, win_req, idle, timeout_flag;
  logic [7:0] out_byte;

  epd_seq_top #(.RST_MS(RST_T), .CMD_MS(CMD_T), .BUSY_SHORT_MS(BS_T),
                .BUSY_LONG_MS(BL_T)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_init(start_init),
    .start_refresh(start_refresh), .busy_i(busy), .panel_rst_n(panel_rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_is_data(out_is_data), .out_last(out_last), .win_req(win_req),
    .win_ack(win_ack), .idle(idle), .timeout_flag(timeout_flag));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] exp_q[$];   // {last, is_data, byte}
  int tdiv = 0, rmode = 0, bmode = 0, busy_cnt = 0, wcnt = 0;
  int lowticks = 0, trig_ticks = 0;
  bit trig_on = 0, win_viol = 0, hold_pend = 0;
  logic [9:0] held;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pcmd(logic [7:0] b); exp_q.push_back({1'b1, 1'b0, b}); endtask
  task automatic pdat(logic [7:0] b, logic l); exp_q.push_back({l, 1'b1, b}); endtask

  task automatic push_init();
    pcmd(8'h12); pcmd(8'h18); pdat(8'h80, 1); pcmd(8'h22); pdat(8'hB1, 1);
    pcmd(8'h20); pcmd(8'h1A); pdat(8'h64, 0); pdat(8'h00, 1);
    pcmd(8'h22); pdat(8'h91, 1); pcmd(8'h20);
  endtask

  task automatic push_ref();
    pcmd(8'h21); pdat(8'h40, 0); pdat(8'h10, 1); pcmd(8'h1A);
    pdat(8'h64, 0); pdat(8'h00, 1); pcmd(8'h22); pdat(8'hD7, 1); pcmd(8'h20);
  endtask

  // input drivers: change just after the rising edge
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % TICK_DIV;
    tick = (tdiv == 0);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rmode == 0) ? 1'b1 : lfsr[0];
  end

  // reference model and monitor, at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(out_valid && {out_last, out_is_data, out_byte} == held, "R3",
            "stalled byte changed", {out_valid, out_last, out_is_data, out_byte},
            {1'b1, held});
      end
      hold_pend = out_valid && !out_ready;
      held = {out_last, out_is_data, out_byte};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected byte", {out_last, out_is_data, out_byte}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({out_last, out_is_data, out_byte} == e, "R2", "stream byte",
              {out_last, out_is_data, out_byte}, e);
        end
        if (!out_is_data && (out_byte == 8'h18 || out_byte == 8'h1A) && bmode == 1)
          chk(busy == 0, "R5", "byte offered while busy", busy, 0);
        if (!out_is_data && (out_byte == 8'h12 || out_byte == 8'h20) && bmode == 1)
          busy_cnt = BUSY_CYC;
        if (!out_is_data && out_byte == 8'h20) begin
          trig_on = 1; trig_ticks = 0;
        end
      end
      if (trig_on && !idle && tick) trig_ticks++;
      if (idle) trig_on = 0;
      if (!panel_rst_n && tick) lowticks++;
      if (win_req) begin
        if (out_valid) win_viol = 1;
        wcnt++;
        win_ack = (wcnt == WIN_WAIT);
      end else begin
        wcnt = 0; win_ack = 0;
      end
      if (bmode == 2) busy = 1;
      else if (busy_cnt > 0) begin busy = 1; busy_cnt--; end
      else busy = 0;
    end
  end

  task automatic run_op(bit ini, bit rf, bit mid_init);
    int n;
    @(posedge clk); #1;
    start_init = ini; start_refresh = rf;
    @(posedge clk); #1;
    start_init = 0; start_refresh = 0;
    n = 0;
    while (!idle && n < 20000) begin
      @(posedge clk); #1; n++;
      if (mid_init && n == 20) start_init = 1;
      if (mid_init && n == 21) start_init = 0;
    end
    chk(n < 20000, "R2", "operation did not finish", n, 0);
    @(negedge clk);
    chk(exp_q.size() == 0, "R2", "bytes missing", exp_q.size(), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=0x1 expected=0x0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(panel_rst_n == 1, "R1", "panel_rst_n", panel_rst_n, 1);
    chk(idle == 1, "R1", "idle", idle, 1);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(win_req == 0, "R1", "win_req", win_req, 0);
    chk(timeout_flag == 0, "R1", "timeout_flag", timeout_flag, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // T1: init, short busy pulses, random back-pressure (R2 R3 R4 R5)
    rmode = 1; bmode = 1; lowticks = 0; push_init();
    run_op(1, 0, 0);
    chk(lowticks >= RST_T && lowticks <= RST_T + 1, "R4", "reset low ticks", lowticks, RST_T);
    chk(panel_rst_n == 1, "R4", "reset released", panel_rst_n, 1);
    chk(timeout_flag == 0, "R5", "no timeout expected", timeout_flag, 0);

    // T2: refresh, delayed ack, start_init mid-op (R8 R9)
    win_viol = 0; push_ref();
    run_op(0, 1, 1);
    chk(!win_viol, "R8", "byte before window ack", win_viol, 0);
    repeat (100) @(negedge clk);
    chk(idle == 1 && exp_q.size() == 0, "R9", "ignored start ran", idle, 1);

    // T3: init with busy stuck high (R6)
    rmode = 0; bmode = 2; push_init();
    run_op(1, 0, 0);
    chk(timeout_flag == 1, "R6", "timeout flag after stuck busy", timeout_flag, 1);
    chk(trig_ticks >= BS_T && trig_ticks <= BS_T + 2, "R10", "init busy limit", trig_ticks, BS_T);
    repeat (50) @(negedge clk);
    chk(timeout_flag == 1, "R6", "timeout flag sticky", timeout_flag, 1);

    // T4: refresh with busy low; flag clears at start (R7)
    bmode = 0; busy = 0; push_ref();
    @(posedge clk); #1; start_refresh = 1;
    @(posedge clk); #1; start_refresh = 0;
    @(negedge clk);
    chk(timeout_flag == 0, "R7", "flag cleared on accept", timeout_flag, 0);
    while (!idle) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "refresh stream complete", exp_q.size(), 0);
    chk(timeout_flag == 0, "R7", "no new timeout", timeout_flag, 0);

    // T5: refresh with busy stuck, long limit (R10)
    bmode = 2; push_ref();
    run_op(0, 1, 0);
    chk(trig_ticks >= BL_T && trig_ticks <= BL_T + 2, "R10", "refresh busy limit", trig_ticks, BL_T);
    chk(timeout_flag == 1, "R10", "refresh timeout flag", timeout_flag, 1);

    // T6: both starts together, init wins (R11)
    bmode = 1; rmode = 1; busy = 0; lowticks = 0; push_init();
    repeat (5) @(negedge clk);
    run_op(1, 1, 0);
    chk(lowticks >= RST_T, "R11", "init reset pulse seen", lowticks, RST_T);
    chk(timeout_flag == 0, "R11", "init completed cleanly", timeout_flag, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule